// File: doc/BRIEF.md
# DRAM Rank Power-State Controller

This block sits inside a DDR3-class memory controller and owns the clock-enable (CKE) line of every memory rank. It keeps CKE low through reset and through a start-up window of a minimum number of clock cycles. CKE may rise only once that window has elapsed and software has set the enable input. After that, each rank runs its own power state machine with four states: ACTIVE, PRECHARGING, POWERDOWN and SELFREFRESH. The machine parks the rank in the cheapest state that the platform power state and the traffic allow.

In the run state a rank drops into dynamic power-down once its idle counter reaches a programmable threshold. A mode input chooses between two kinds of power-down. Active power-down leaves the pages open. Precharge power-down first issues one precharge-all cycle and then drops CKE.

In the deep package idle state, ranks go to self-refresh when no request is pending and the memory pipeline has been flushed. When integrated graphics is in use, the graphics engine must also be idle with no pending display fetch. If any of these conditions fails, ranks fall back to dynamic power-down. In suspend-to-RAM, every eligible rank goes to self-refresh and CKE stays low. In suspend-to-disk, all ranks are shut off until the next reset. Ranks that hold graphics memory never enter self-refresh. A request to a sleeping rank raises its CKE at once, and the grant comes only after a fixed exit latency.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: While reset is active, and after reset until the enable input has been seen high, every CKE output is 0.
- R2: After reset release, CKE stays 0 for at least MIN_LOW_CYC clock cycles even when the enable input is already high. With enable high it rises within MIN_LOW_CYC+3 cycles.
- R3: In the run state (pwr_state 2'b00) with pd_mode 0, a rank whose request drops enters power-down with no precharge-all. Its CKE goes low idle_thresh+1 cycles later.
- R4: With pd_mode 1, the rank first asserts pre_all for exactly one cycle, idle_thresh+1 cycles after its request drops, with CKE still high. CKE goes low in the next cycle.
- R5: A request to a rank in power-down raises its CKE in the next cycle. The grant appears PD_LAT+1 cycles after the request, and a grant is never given while CKE is low.
- R6: A request to a rank in self-refresh outside suspend is granted SR_LAT+1 cycles after the request.
- R7: In the deep idle state (pwr_state 2'b01), self-refresh is entered only if all of these hold: no request is pending on any rank, flush_done is 1, and, when gfx_igpu is 1, gfx_idle is 1 and disp_pend is 0. If the graphics conditions fail, ranks stay in power-down. If only flush_done is 0, ranks wait awake with CKE high.
- R8: A rank whose gfx_mask bit is 1 never enters self-refresh.
- R9: In suspend (pwr_state 2'b10), every rank with gfx_mask 0 enters self-refresh. While suspend lasts, a request to such a rank leaves its CKE low and its grant 0.
- R10: Once pwr_state 2'b11 (suspend-to-disk) is seen, every CKE and grant stays 0 until reset, whatever the later inputs.
- R11: Each entry to self-refresh produces exactly one single-cycle sr_enter pulse on that rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke_en | input | 1 | Software enable that allows CKE to rise |
| pwr_state | input | 2 | 00 run, 01 deep idle, 10 suspend-to-RAM, 11 suspend-to-disk |
| pd_mode | input | 1 | 0 active power-down, 1 precharge power-down |
| idle_thresh | input | IDLE_W | Idle cycles before power-down entry |
| flush_done | input | 1 | Pending memory cycles have drained |
| gfx_igpu | input | 1 | Integrated graphics is in use |
| gfx_idle | input | 1 | Graphics engine is idle |
| disp_pend | input | 1 | Display fetch is pending |
| gfx_mask | input | N_RANKS | Ranks that hold graphics memory |
| req | input | N_RANKS | Request pending per rank |
| grant | output | N_RANKS | Request may proceed this cycle |
| cke | output | N_RANKS | Clock enable per rank |
| pre_all | output | N_RANKS | Precharge-all command per rank |
| sr_enter | output | N_RANKS | Self-refresh entry pulse per rank |

## Verification
The bench counts exact latencies:
- **Start-up:** a gate that honoured an early enable would raise CKE before MIN_LOW_CYC.
- **Power-down entry:** an off-by-one idle compare would shift the power-down edge.
- **Exit:** an exit counter loaded with the wrong latency would move the grant.

Each self-refresh condition is withheld one at a time:
- **Graphics busy or display pending:** a design that ignored either would show an sr_enter pulse.
- **flush_done low:** a design that ignored it would leave CKE low instead of holding the ranks awake.

The remaining cases are:
- **Graphics-owned rank:** it must stay out of self-refresh throughout, including in suspend.
- **Suspend with a request:** a design that let the request wake the rank would raise CKE.
- **Suspend-to-disk:** a design that did not latch it would resume granting.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    typedef enum logic [1:0] {
        PWR_RUN     = 2'b00,
        PWR_DEEP    = 2'b01,
        PWR_SUSPEND = 2'b10,
        PWR_OFF     = 2'b11
    } pwr_e;

    typedef enum logic [1:0] {
        RK_ACTIVE = 2'b00,
        RK_PRECHG = 2'b01,
        RK_PDOWN  = 2'b10,
        RK_SREF   = 2'b11
    } rk_state_e;

endpackage

// File: rtl/rpc_startup_gate.sv
module rpc_startup_gate #(
    parameter int MIN_LOW_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cke_en,
    output logic ready
);
    localparam int CW = $clog2(MIN_LOW_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } gate_t;

    gate_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.cnt != LIMIT) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
        if (cur_q.cnt == LIMIT && cke_en) begin
            nxt_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign ready = cur_q.done;

    // R2: the gate can only open once the full low window has been counted
    p_min_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.done |-> cur_q.cnt == LIMIT);

    // R1: opening needs the software enable
    p_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.done) |-> $past(cke_en));

endmodule

// File: rtl/rpc_sr_policy.sv
module rpc_sr_policy
    import rpc_pkg::*;
#(
    parameter int N_RANKS = 4
) (
    input  logic [1:0]         pwr_state,
    input  logic [N_RANKS-1:0] req,
    input  logic               gfx_igpu,
    input  logic               gfx_idle,
    input  logic               disp_pend,
    input  logic [N_RANKS-1:0] gfx_mask,
    output logic [N_RANKS-1:0] sr_want,
    output logic               suspend,
    output logic               run_state
);
    pwr_e pwr;
    logic deep_ok;

    always_comb begin
        pwr       = pwr_e'(pwr_state);
        suspend   = (pwr == PWR_SUSPEND);
        run_state = (pwr == PWR_RUN);
        deep_ok   = (pwr == PWR_DEEP) && (req == '0)
                    && (!gfx_igpu || (gfx_idle && !disp_pend));
    end

    for (genvar g = 0; g < N_RANKS; g++) begin : g_want
        assign sr_want[g] = !gfx_mask[g] && (suspend || deep_ok);
    end

endmodule

// File: rtl/rpc_rank_fsm.sv
module rpc_rank_fsm
    import rpc_pkg::*;
#(
    parameter int IDLE_W = 8,
    parameter int PD_LAT = 3,
    parameter int SR_LAT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              req,
    input  logic              pd_mode,
    input  logic [IDLE_W-1:0] idle_thresh,
    input  logic              sr_want,
    input  logic              suspend,
    input  logic              run_state,
    input  logic              flush_done,
    output logic              cke,
    output logic              pre_all,
    output logic              grant,
    output logic              sr_enter
);
    localparam int MAX_LAT = (SR_LAT > PD_LAT) ? SR_LAT : PD_LAT;
    localparam int EW      = $clog2(MAX_LAT + 1);
    localparam logic [EW-1:0]     PD_EXIT  = EW'(PD_LAT);
    localparam logic [EW-1:0]     SR_EXIT  = EW'(SR_LAT);
    localparam logic [IDLE_W-1:0] IDLE_MAX = '1;

    typedef struct packed {
        rk_state_e         state;
        logic [IDLE_W-1:0] idle;
        logic [EW-1:0]     exit_cnt;
        logic              tgt_sr;
        logic              sr_pulse;
    } rank_t;

    rank_t cur_q, nxt_d;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.sr_pulse = 1'b0;
        if (!run) begin
            nxt_d.state    = RK_ACTIVE;
            nxt_d.idle     = '0;
            nxt_d.exit_cnt = '0;
            nxt_d.tgt_sr   = 1'b0;
        end else begin
            unique case (cur_q.state)
                RK_ACTIVE: begin
                    if (cur_q.exit_cnt != '0) begin
                        nxt_d.exit_cnt = cur_q.exit_cnt - 1'b1;
                        nxt_d.idle     = '0;
                    end else begin
                        if (req) begin
                            nxt_d.idle = '0;
                        end else if (cur_q.idle != IDLE_MAX) begin
                            nxt_d.idle = cur_q.idle + 1'b1;
                        end
                        if (sr_want) begin
                            if (flush_done && !req) begin
                                nxt_d.state  = RK_PRECHG;
                                nxt_d.tgt_sr = 1'b1;
                            end
                        end else if (!req && cur_q.idle >= idle_thresh) begin
                            nxt_d.tgt_sr = 1'b0;
                            nxt_d.state  = pd_mode ? RK_PRECHG : RK_PDOWN;
                        end
                    end
                end
                RK_PRECHG: begin
                    if (cur_q.tgt_sr && sr_want) begin
                        nxt_d.state    = RK_SREF;
                        nxt_d.sr_pulse = 1'b1;
                    end else begin
                        nxt_d.state = RK_PDOWN;
                    end
                    nxt_d.tgt_sr = 1'b0;
                end
                RK_PDOWN: begin
                    if (req || sr_want) begin
                        nxt_d.state    = RK_ACTIVE;
                        nxt_d.exit_cnt = PD_EXIT;
                        nxt_d.idle     = '0;
                    end
                end
                RK_SREF: begin
                    if ((req && !suspend) || run_state) begin
                        nxt_d.state    = RK_ACTIVE;
                        nxt_d.exit_cnt = SR_EXIT;
                        nxt_d.idle     = '0;
                    end
                end
                default: nxt_d.state = RK_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{state: RK_ACTIVE, idle: '0, exit_cnt: '0,
                       tgt_sr: 1'b0, sr_pulse: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cke      = run && (cur_q.state == RK_ACTIVE || cur_q.state == RK_PRECHG);
    assign pre_all  = run && (cur_q.state == RK_PRECHG);
    assign grant    = run && (cur_q.state == RK_ACTIVE) && (cur_q.exit_cnt == '0) && req;
    assign sr_enter = cur_q.sr_pulse;

    // R5: a grant never comes in the same cycle CKE first rises
    p_grant_after_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && $past(run)) |-> $past(cke));

    // R4: entering power-down straight from ACTIVE only in active mode
    p_prechg_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == RK_PDOWN && $past(cur_q.state) == RK_ACTIVE && $past(run))
        |-> !$past(pd_mode));

    // R7: self-refresh entry needs the flush seen at the decision cycle
    p_sr_flushed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.sr_pulse |-> $past(flush_done, 2));

    // R11: the entry pulse is one cycle wide and marks the new state
    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.sr_pulse |=> !cur_q.sr_pulse);
    p_pulse_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.sr_pulse |-> cur_q.state == RK_SREF);

endmodule

// File: rtl/rank_pwr_ctrl.sv
module rank_pwr_ctrl
    import rpc_pkg::*;
#(
    parameter int N_RANKS     = 4,
    parameter int IDLE_W      = 8,
    parameter int MIN_LOW_CYC = 200,
    parameter int PD_LAT      = 3,
    parameter int SR_LAT      = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cke_en,
    input  logic [1:0]         pwr_state,
    input  logic               pd_mode,
    input  logic [IDLE_W-1:0]  idle_thresh,
    input  logic               flush_done,
    input  logic               gfx_igpu,
    input  logic               gfx_idle,
    input  logic               disp_pend,
    input  logic [N_RANKS-1:0] gfx_mask,
    input  logic [N_RANKS-1:0] req,
    output logic [N_RANKS-1:0] grant,
    output logic [N_RANKS-1:0] cke,
    output logic [N_RANKS-1:0] pre_all,
    output logic [N_RANKS-1:0] sr_enter
);
    typedef struct packed {
        logic off;
    } top_t;

    top_t cur_q, nxt_d;
    logic ready;
    logic run;
    logic suspend;
    logic run_state;
    logic [N_RANKS-1:0] sr_want;

    always_comb begin
        nxt_d = cur_q;
        if (pwr_e'(pwr_state) == PWR_OFF) begin
            nxt_d.off = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign run = rst_n && ready && !cur_q.off;

    rpc_startup_gate #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke_en (cke_en),
        .ready  (ready)
    );

    rpc_sr_policy #(.N_RANKS(N_RANKS)) u_policy (
        .pwr_state (pwr_state),
        .req       (req),
        .gfx_igpu  (gfx_igpu),
        .gfx_idle  (gfx_idle),
        .disp_pend (disp_pend),
        .gfx_mask  (gfx_mask),
        .sr_want   (sr_want),
        .suspend   (suspend),
        .run_state (run_state)
    );

    for (genvar g = 0; g < N_RANKS; g++) begin : g_rank
        rpc_rank_fsm #(
            .IDLE_W (IDLE_W),
            .PD_LAT (PD_LAT),
            .SR_LAT (SR_LAT)
        ) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .run         (run),
            .req         (req[g]),
            .pd_mode     (pd_mode),
            .idle_thresh (idle_thresh),
            .sr_want     (sr_want[g]),
            .suspend     (suspend),
            .run_state   (run_state),
            .flush_done  (flush_done),
            .cke         (cke[g]),
            .pre_all     (pre_all[g]),
            .grant       (grant[g]),
            .sr_enter    (sr_enter[g])
        );

        // R8: the self-refresh decision was taken while the rank was not graphics-owned
        p_gfx_no_sr_r8: assert property (@(posedge clk) disable iff (!rst_n)
            sr_enter[g] |-> !$past(gfx_mask[g]));
    end

    // R1: nothing wakes before the start-up gate opens
    p_hold_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> cke == '0);

    // R10: after suspend-to-disk everything stays quiet
    p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.off |-> (cke == '0 && grant == '0));

endmodule

// File: tb/sim_rank_pwr_ctrl.sv
module sim_rank_pwr_ctrl;
    localparam int N   = 4;
    localparam int IW  = 8;
    localparam int MIN = 200;
    localparam int PDL = 3;
    localparam int SRL = 12;
    localparam int T   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_en = 1'b0;
    logic [1:0] pwr_state = 2'b00;
    logic pd_mode = 1'b0;
    logic [IW-1:0] idle_thresh = '1;
    logic flush_done = 1'b0;
    logic gfx_igpu = 1'b0;
    logic gfx_idle = 1'b0;
    logic disp_pend = 1'b0;
    logic [N-1:0] gfx_mask = '0;
    logic [N-1:0] req = '0;
    logic [N-1:0] grant, cke, pre_all, sr_enter;

    int checks = 0;
    int fails = 0;
    int sr_cnt [N];

    always #4 clk = ~clk;

    rank_pwr_ctrl #(.N_RANKS(N), .IDLE_W(IW), .MIN_LOW_CYC(MIN),
                    .PD_LAT(PDL), .SR_LAT(SRL)) u0 (
        .clk(clk), .rst_n(rst_n), .cke_en(cke_en), .pwr_state(pwr_state),
        .pd_mode(pd_mode), .idle_thresh(idle_thresh), .flush_done(flush_done),
        .gfx_igpu(gfx_igpu), .gfx_idle(gfx_idle), .disp_pend(disp_pend),
        .gfx_mask(gfx_mask), .req(req), .grant(grant), .cke(cke),
        .pre_all(pre_all), .sr_enter(sr_enter)
    );

    function automatic int exp_pd_entry(bit mode);
        return mode ? T + 2 : T + 1;
    endfunction

    function automatic int exp_wake(bit from_sr);
        return from_sr ? SRL + 1 : PDL + 1;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++) sr_cnt[i] += int'(sr_enter[i]);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wake_lat(int r, output int n);
        req[r] = 1'b1;
        n = 0;
        while (!grant[r] && n < 300) begin
            tick();
            n++;
        end
        req[r] = 1'b0;
    endtask

    task automatic until_low(int r, output int n, output int pre_at);
        n = 0;
        pre_at = -1;
        while (cke[r] && n < 300) begin
            tick();
            n++;
            if (pre_all[r] && pre_at < 0) pre_at = n;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ticks(5);
        chk(cke == '0, "R1 cke in reset", int'(cke), 0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n, pre_at, bad, bad2;
        void'($urandom(32'd7));
        for (int i = 0; i < N; i++) sr_cnt[i] = 0;
        @(negedge clk);

        // R1: no enable means CKE never rises
        do_reset();
        ticks(MIN + 20);
        chk(cke == '0, "R1 cke without enable", int'(cke), 0);

        // R2: early enable still waits for the full window
        cke_en = 1'b1;
        do_reset();
        ticks(MIN);
        chk(cke == '0, "R2 cke at window end", int'(cke), 0);
        ticks(3);
        chk(cke == '1, "R2 cke after window", int'(cke), 15);

        // R3: active power-down
        idle_thresh = IW'(T);
        pd_mode = 1'b0;
        ticks(20);
        chk(cke == '0, "R3 all ranks idle", int'(cke), 0);
        wake_lat(0, n);
        chk(n == exp_wake(1'b0), "R5 pd exit latency", n, exp_wake(1'b0));
        until_low(0, n, pre_at);
        chk(n == exp_pd_entry(1'b0), "R3 entry delay", n, exp_pd_entry(1'b0));
        chk(pre_at == -1, "R3 no precharge", pre_at, -1);

        // R5: CKE rises in the cycle after the request
        req[2] = 1'b1;
        tick();
        chk(cke[2] == 1'b1, "R5 cke rises", int'(cke[2]), 1);
        chk(grant[2] == 1'b0, "R5 grant held off", int'(grant[2]), 0);
        req[2] = 1'b0;
        ticks(20);

        // R4: precharge power-down
        pd_mode = 1'b1;
        wake_lat(1, n);
        chk(n == exp_wake(1'b0), "R5 pd exit latency r1", n, exp_wake(1'b0));
        until_low(1, n, pre_at);
        chk(pre_at == T + 1, "R4 precharge cycle", pre_at, T + 1);
        chk(n == exp_pd_entry(1'b1), "R4 entry delay", n, exp_pd_entry(1'b1));

        // R7: deep idle, graphics busy blocks self-refresh
        gfx_mask = 4'b1000;
        pwr_state = 2'b01;
        flush_done = 1'b1;
        gfx_igpu = 1'b1;
        gfx_idle = 1'b0;
        disp_pend = 1'b0;
        for (int i = 0; i < N; i++) sr_cnt[i] = 0;
        ticks(30);
        chk(cke == '0 && sr_cnt[0] == 0, "R7 gfx busy", int'(cke) + sr_cnt[0], 0);
        gfx_idle = 1'b1;
        disp_pend = 1'b1;
        ticks(30);
        chk(cke == '0 && sr_cnt[1] == 0, "R7 display pending", int'(cke) + sr_cnt[1], 0);

        // R7: flush not done holds ranks awake
        disp_pend = 1'b0;
        flush_done = 1'b0;
        ticks(30);
        chk(cke == 4'b0111, "R7 waiting for flush", int'(cke), 7);
        chk(sr_cnt[2] == 0, "R7 no entry before flush", sr_cnt[2], 0);
        flush_done = 1'b1;
        ticks(10);
        chk(cke == '0, "R7 all asleep", int'(cke), 0);
        for (int i = 0; i < 3; i++)
            chk(sr_cnt[i] == 1, "R11 one entry pulse", sr_cnt[i], 1);
        chk(sr_cnt[3] == 0, "R8 gfx rank kept out", sr_cnt[3], 0);

        // R6: exit from self-refresh
        wake_lat(0, n);
        chk(n == exp_wake(1'b1), "R6 sr exit latency", n, exp_wake(1'b1));
        ticks(10);
        chk(sr_cnt[0] == 2, "R11 re-entry pulse", sr_cnt[0], 2);
        chk(cke == '0, "R6 back asleep", int'(cke), 0);

        // R9: suspend from power-down
        pwr_state = 2'b00;
        ticks(60);
        chk(cke == '0, "R9 ranks in power-down", int'(cke), 0);
        for (int i = 0; i < N; i++) sr_cnt[i] = 0;
        pwr_state = 2'b10;
        ticks(20);
        for (int i = 0; i < 3; i++)
            chk(sr_cnt[i] == 1, "R9 suspend entry", sr_cnt[i], 1);
        chk(sr_cnt[3] == 0, "R8 gfx rank in suspend", sr_cnt[3], 0);
        req[1] = 1'b1;
        bad = 0;
        for (int i = 0; i < 30; i++) begin
            tick();
            if (cke[1] || grant[1]) bad++;
        end
        req[1] = 1'b0;
        chk(bad == 0, "R9 request ignored in suspend", bad, 0);

        // random phase
        pwr_state = 2'b00;
        gfx_mask = 4'b1000;
        bad = 0;
        bad2 = 0;
        for (int i = 0; i < N; i++) sr_cnt[i] = 0;
        for (int i = 0; i < 2000; i++) begin
            if (i % 50 == 0) begin
                pwr_state = ($urandom % 2 == 0) ? 2'b00 : 2'b01;
                pd_mode = 1'($urandom % 2);
                gfx_idle = 1'($urandom % 2);
            end
            req = N'($urandom % 16) & N'($urandom % 16);
            tick();
            if ((grant & ~cke) != '0) bad++;
            if (sr_enter[3]) bad2++;
        end
        req = '0;
        chk(bad == 0, "R5 grant only with cke", bad, 0);
        chk(bad2 == 0, "R8 random gfx rank", bad2, 0);

        // R10: suspend-to-disk is sticky
        pwr_state = 2'b11;
        tick();
        pwr_state = 2'b00;
        req = '1;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (cke != '0 || grant != '0) bad++;
        end
        req = '0;
        chk(bad == 0, "R10 memory off", bad, 0);

        finish_run();
    end

endmodule